// File: doc/BRIEF.md
# Code and Data Space Decoder

This block sits beside an 8-bit controller core that has separate code and data address spaces. For each access it decides whether the target is on-chip or off-chip memory. For external accesses it also produces chip selects for an external program ROM, a 32Kx8 SRAM in the lower half of data space and an I/O region in the upper half.

The code-space split is set by an external-access pin. That pin is captured only while reset is held, and the captured mode stays fixed until the next reset. Some on-chip RAM configurations are larger than 256 bytes; the bytes beyond 256 overlay the bottom of external data space, and a control bit chooses whether accesses to that overlay stay on-chip or go out.

A build-time option merges code and data into one 64KB external space. In that option the code and data read strobes are combined into a single active-low read strobe, and external code fetches are decoded like data accesses. Apart from the mode capture register, all selects are combinational.

Top module: `mem_space_decoder`

## Requirements
- R1: The mode is captured from `ext_code_pin` on every clock edge while `rst_n` is low. After reset it holds its value whatever the pin does.
- R2: With the captured pin at 1, every active code fetch (`is_code`=1, `psen_n`=0) is external at any address.
- R3: With the captured pin at 0, a code fetch below CODE_INT_BYTES (default 4096, so 0x0000..0x0FFF) is internal (`ext_sel`=0, `rom_sel`=0), and a fetch at or above it is external.
- R4: In the separate-space build, an external code fetch asserts `rom_sel` and neither `sram_sel` nor `io_sel`.
- R5: A data access (`is_code`=0 with `rd_n`=0 or `wr_n`=0) whose address is below the overlay size INT_RAM_BYTES-256 (default 768) is internal when `aux_ram_off`=0 and external when it is 1. Addresses at or above the overlay size are always external. With INT_RAM_BYTES of 256 or less there is no overlay.
- R6: An external data access with address bit 15 at 0 asserts `sram_sel` only.
- R7: An external data access with address bit 15 at 1 asserts `io_sel` only.
- R8: With no active access, `ext_sel`, `rom_sel` and `io_sel` are 0, and `sram_sel` equals the inverse of `hi_port_b7`.
- R9: In the merged build, `merged_rd_n` is the AND of `psen_n` and `rd_n`. External code fetches then decode as R6/R7 by bit 15, and `rom_sel` stays 0. In the separate build, `merged_rd_n` is held at 1.
- R10: The captured mode has no effect on data-space decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode capture register |
| rst_n | input | 1 | Active-low synchronous reset; the mode is captured while it is low |
| ext_code_pin | input | 1 | External-access request: 1 means the whole code space is external |
| aux_ram_off | input | 1 | 1 sends overlay-region data accesses off-chip |
| is_code | input | 1 | 1 for a code fetch, 0 for a data access |
| addr | input | 16 | Access address |
| psen_n | input | 1 | Active-low code read strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low data write strobe |
| hi_port_b7 | input | 1 | Bit 7 of the value the upper address port shows between accesses |
| ext_sel | output | 1 | The active access targets external memory |
| rom_sel | output | 1 | External program ROM select |
| sram_sel | output | 1 | External SRAM select (lower 32KB) |
| io_sel | output | 1 | External I/O region select (upper 32KB) |
| merged_rd_n | output | 1 | Combined active-low read strobe (merged build) |

## Verification
The bench builds two instances side by side. The first uses the defaults (4096-byte internal code, 1024-byte internal RAM, separate spaces), which puts both the 0x0FFF/0x1000 code boundary and the 767/768 overlay boundary within reach. The second is a merged-space build with 256 bytes of RAM; it exercises the combined strobe, the absence of any overlay and code fetches decoding as SRAM or I/O. Resets with each pin value, and pin toggles after reset, cover both capture modes.

// File: rtl/msd_pkg.sv
`timescale 1ns/1ps
package msd_pkg;
  typedef enum logic {
    MODE_SPLIT   = 1'b0,
    MODE_ALL_EXT = 1'b1
  } code_mode_e;

  typedef struct packed {
    logic ext;
    logic rom;
    logic sram;
    logic io;
  } sel_t;

  function automatic int overlay_bytes(input int ram_bytes);
    return (ram_bytes > 256) ? (ram_bytes - 256) : 0;
  endfunction
endpackage

// File: rtl/msd_mode_latch.sv
`timescale 1ns/1ps
module msd_mode_latch
  import msd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  output code_mode_e mode
);
  // Tracks the pin only while reset is held, then freezes.
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= pin ? MODE_ALL_EXT : MODE_SPLIT;
  end
endmodule

// File: rtl/msd_code_dec.sv
`timescale 1ns/1ps
module msd_code_dec
  import msd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int CODE_INT_BYTES = 4096,
  parameter bit MERGE          = 1'b0
) (
  input  code_mode_e        mode,
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  localparam logic [31:0] LIMIT = CODE_INT_BYTES;
  localparam int PAD = 32 - ADDR_W;

  logic above;
  logic ext;
  assign above = {{PAD{1'b0}}, addr} >= LIMIT;
  assign ext   = active && ((mode == MODE_ALL_EXT) || above);

  generate
    if (MERGE) begin : g_merged
      always_comb begin
        sel.ext  = ext;
        sel.rom  = 1'b0;
        sel.sram = ext && !addr[ADDR_W-1];
        sel.io   = ext &&  addr[ADDR_W-1];
      end
    end else begin : g_split
      always_comb begin
        sel.ext  = ext;
        sel.rom  = ext;
        sel.sram = 1'b0;
        sel.io   = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/msd_data_dec.sv
`timescale 1ns/1ps
module msd_data_dec
  import msd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int INT_RAM_BYTES = 1024
) (
  input  logic              active,
  input  logic              aux_off,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  localparam int OVL = overlay_bytes(INT_RAM_BYTES);
  localparam int PAD = 32 - ADDR_W;

  logic in_ovl;
  generate
    if (OVL > 0) begin : g_ovl
      localparam logic [31:0] OVL_LIM = OVL;
      assign in_ovl = {{PAD{1'b0}}, addr} < OVL_LIM;
    end else begin : g_no_ovl
      assign in_ovl = 1'b0;
    end
  endgenerate

  logic ext;
  assign ext = active && !(in_ovl && !aux_off);

  always_comb begin
    sel.ext  = ext;
    sel.rom  = 1'b0;
    sel.sram = ext && !addr[ADDR_W-1];
    sel.io   = ext &&  addr[ADDR_W-1];
  end
endmodule

// File: rtl/mem_space_decoder.sv
`timescale 1ns/1ps
module mem_space_decoder
  import msd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int CODE_INT_BYTES = 4096,
  parameter int INT_RAM_BYTES  = 1024,
  parameter bit MERGE          = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_code_pin,
  input  logic              aux_ram_off,
  input  logic              is_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              hi_port_b7,
  output logic              ext_sel,
  output logic              rom_sel,
  output logic              sram_sel,
  output logic              io_sel,
  output logic              merged_rd_n
);
  code_mode_e code_mode;
  logic       code_act;
  logic       data_act;
  sel_t       c_sel;
  sel_t       d_sel;

  assign code_act = is_code && !psen_n;
  assign data_act = !is_code && (!rd_n || !wr_n);

  msd_mode_latch u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_code_pin),
    .mode (code_mode)
  );

  msd_code_dec #(
    .ADDR_W        (ADDR_W),
    .CODE_INT_BYTES(CODE_INT_BYTES),
    .MERGE         (MERGE)
  ) u_code (
    .mode  (code_mode),
    .active(code_act),
    .addr  (addr),
    .sel   (c_sel)
  );

  msd_data_dec #(
    .ADDR_W       (ADDR_W),
    .INT_RAM_BYTES(INT_RAM_BYTES)
  ) u_data (
    .active (data_act),
    .aux_off(aux_ram_off),
    .addr   (addr),
    .sel    (d_sel)
  );

  always_comb begin
    ext_sel = c_sel.ext || d_sel.ext;
    rom_sel = c_sel.rom;
    io_sel  = c_sel.io || d_sel.io;
    // Between accesses the SRAM enable follows the idle upper-port bit.
    if (code_act || data_act) sram_sel = c_sel.sram || d_sel.sram;
    else                      sram_sel = !hi_port_b7;
  end

  generate
    if (MERGE) begin : g_mrg
      assign merged_rd_n = psen_n && rd_n;
    end else begin : g_sep
      assign merged_rd_n = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/mem_space_decoder_chk.sv
`timescale 1ns/1ps
module mem_space_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        code_mode,
  input logic        is_code,
  input logic [15:0] addr,
  input logic        psen_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        hi_port_b7,
  input logic        ext_sel,
  input logic        rom_sel,
  input logic        sram_sel,
  input logic        io_sel
);
  logic any_act;
  assign any_act = (is_code && !psen_n) || (!is_code && (!rd_n || !wr_n));

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(code_mode));

  p_all_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_mode && is_code && !psen_n) |-> ext_sel);

  p_rom_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (is_code && !psen_n && ext_sel));

  p_io_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (addr[15] && ext_sel));

  p_sram_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act && sram_sel) |-> !addr[15]);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act |-> (!ext_sel && !rom_sel && !io_sel && (sram_sel == !hi_port_b7)));

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> $onehot0({rom_sel, sram_sel, io_sel}));
endmodule

bind mem_space_decoder mem_space_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .code_mode (code_mode),
  .is_code   (is_code),
  .addr      (addr),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .hi_port_b7(hi_port_b7),
  .ext_sel   (ext_sel),
  .rom_sel   (rom_sel),
  .sram_sel  (sram_sel),
  .io_sel    (io_sel)
);

// File: tb/mem_space_decoder_tb.sv
`timescale 1ns/1ps
module mem_space_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        aux_off = 1'b0;
  logic        is_code = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        psen_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        b7 = 1'b1;
  logic        a_ext, a_rom, a_sram, a_io, a_mrg;
  logic        m_ext, m_rom, m_sram, m_io, m_mrg;

  int checks = 0;
  int fails = 0;
  bit mode = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_space_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ext_code_pin(pin), .aux_ram_off(aux_off),
    .is_code(is_code), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_port_b7(b7), .ext_sel(a_ext), .rom_sel(a_rom), .sram_sel(a_sram),
    .io_sel(a_io), .merged_rd_n(a_mrg)
  );

  mem_space_decoder #(.INT_RAM_BYTES(256), .MERGE(1'b1)) u_dut_m (
    .clk(clk), .rst_n(rst_n), .ext_code_pin(pin), .aux_ram_off(aux_off),
    .is_code(is_code), .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_port_b7(b7), .ext_sel(m_ext), .rom_sel(m_rom), .sram_sel(m_sram),
    .io_sel(m_io), .merged_rd_n(m_mrg)
  );

  typedef struct {
    logic [4:0] ea;
    logic [4:0] em;
    string      req;
  } item_t;
  item_t q[$];

  // Independent model: {ext, rom, sram, io, merged_rd_n}
  function automatic logic [4:0] model(bit merged, int ovl, bit md, logic c,
      logic [15:0] a, logic ps, logic rd, logic wr, logic ao, logic hb);
    logic act, ext;
    logic [4:0] r;
    act = c ? !ps : (!rd || !wr);
    if (!act) ext = 1'b0;
    else if (c) ext = md || (a >= 16'h1000);
    else ext = !((int'(a) < ovl) && !ao);
    r[4] = ext;
    r[3] = ext && c && !merged;
    r[2] = act ? (ext && !a[15] && (!c || merged)) : !hb;
    r[1] = ext && a[15] && (!c || merged);
    r[0] = merged ? (ps && rd) : 1'b1;
    return r;
  endfunction

  task automatic apply(logic c, logic [15:0] a, logic ps, logic rd, logic wr,
      logic ao, logic hb, string req);
    item_t it;
    @(negedge clk);
    is_code = c; addr = a; psen_n = ps; rd_n = rd; wr_n = wr;
    aux_off = ao; b7 = hb;
    it.ea  = model(1'b0, 768, mode, c, a, ps, rd, wr, ao, hb);
    it.em  = model(1'b1, 0, mode, c, a, ps, rd, wr, ao, hb);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst_n = 1'b0; pin = p;
    is_code = 1'b0; psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode = p;
  endtask

  // Monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({a_ext, a_rom, a_sram, a_io, a_mrg} !== it.ea ||
            {m_ext, m_rom, m_sram, m_io, m_mrg} !== it.em) begin
          fails++;
          $display("FAIL %s: actual sep=%b mrg=%b expected sep=%b mrg=%b",
                   it.req, {a_ext, a_rom, a_sram, a_io, a_mrg},
                   {m_ext, m_rom, m_sram, m_io, m_mrg}, it.ea, it.em);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 / R8: reset state with split mode, idle bus
    do_reset(1'b0);
    apply(1'b0, 16'h0000, 1, 1, 1, 0, 1, "R8 idle b7=1");
    apply(1'b0, 16'h0000, 1, 1, 1, 0, 0, "R8 idle b7=0");
    // R3: split code boundary
    apply(1'b1, 16'h0FFF, 0, 1, 1, 0, 1, "R3 code 0FFF internal");
    apply(1'b1, 16'h1000, 0, 1, 1, 0, 1, "R3 R4 R9 code 1000 external");
    apply(1'b1, 16'h9000, 0, 1, 1, 0, 1, "R9 code upper io in merged");
    // R1: pin toggles after reset have no effect
    @(negedge clk); pin = 1'b1;
    apply(1'b1, 16'h0010, 0, 1, 1, 0, 1, "R1 pin change ignored");
    // R5: overlay region
    apply(1'b0, 16'd767, 1, 0, 1, 0, 1, "R5 overlay internal");
    apply(1'b0, 16'd767, 1, 0, 1, 1, 1, "R5 overlay off-chip");
    apply(1'b0, 16'd768, 1, 1, 0, 0, 1, "R5 R6 above overlay write");
    apply(1'b0, 16'h7FFF, 1, 0, 1, 0, 1, "R6 top of sram");
    apply(1'b0, 16'h8000, 1, 1, 0, 0, 0, "R7 io region");
    apply(1'b0, 16'hFFFF, 1, 0, 1, 1, 1, "R7 io top");
    // R9: merged strobe with both strobes idle / code strobe only
    apply(1'b0, 16'h0100, 0, 1, 1, 0, 1, "R9 psen with data flag");
    // R2: external-all mode
    do_reset(1'b1);
    apply(1'b1, 16'h0000, 0, 1, 1, 0, 1, "R2 code 0000 external");
    apply(1'b1, 16'h0FFF, 0, 1, 1, 0, 1, "R2 code 0FFF external");
    @(negedge clk); pin = 1'b0;
    apply(1'b1, 16'h0020, 0, 1, 1, 0, 1, "R1 R2 pin drop ignored");
    // R10: data decoding unchanged by mode
    apply(1'b0, 16'd100, 1, 0, 1, 0, 1, "R10 overlay with all-ext mode");
    apply(1'b0, 16'h4000, 1, 0, 1, 0, 1, "R10 sram with all-ext mode");
    apply(1'b0, 16'h4000, 1, 1, 1, 0, 1, "R8 no strobe");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule